// File: doc/BRIEF.md
# DRAM Bank State Tracker

This block follows the life of a single DRAM bank while a memory controller issues commands to it. Every cycle the scheduler presents the command it actually sent to the bank. The tracker updates its record of the bank from that command:

- whether a row is open, and which row it is;
- whether a request is waiting for the bank;
- whether the bank is asleep in a power-down or self-refresh state;
- whether refresh logic has fenced the bank off.

From that record it proposes the next command the scheduler should consider for the waiting request. That command is an activate, a precharge to close a wrong row, or a column read or write on a row hit.

The tracker holds at most one request. A request is offered with its row and its direction, and it stays pending until a column command completes it. Power-down and self-refresh entry put the bank to sleep. The bank wakes on a power-down exit or on any refresh. A separate fence input blocks the bank until the next refresh. While the bank is asleep or fenced, no command is proposed. Command timing, queueing and arbitration between banks belong to other blocks.

Top module: `bank_state_tracker`

## Requirements
- R1: After a synchronous active-high reset the bank is closed, `open_row` is 0, no request is pending, the bank is neither sleeping nor blocked, and `next_valid` is 0.
- R2: Command code 1 (activate) opens the bank and copies the pending request's row into `open_row` on the next clock edge.
- R3: Code 2 (precharge) and code 3 (precharge all) close the bank.
- R4: Code 4 (read) and code 5 (write) complete the pending request and leave the bank open on the same row.
- R5: Code 6 (read with auto-precharge) and code 7 (write with auto-precharge) complete the pending request and close the bank in the same update.
- R6: Code 8 (active power-down entry), code 9 (precharge power-down entry) and code 10 (self-refresh entry) set the sleeping flag.
- R7: Code 11 (all-bank refresh) and code 12 (per-bank refresh) clear both the sleeping and blocked flags. A `block_set` in the same cycle as a refresh leaves the bank blocked.
- R8: Code 13 (active power-down exit) and code 14 (precharge power-down exit) clear only the sleeping flag. Code 15 (self-refresh exit) and code 0 (no operation) change no state.
- R9: `block_set` sets the blocked flag. While the bank is blocked or sleeping, `next_valid` is 0 and `next_cmd` is 0.
- R10: With a request pending and the bank neither blocked nor sleeping, `next_cmd` depends on the bank state:
  - 4 (read request) or 5 (write request) when the bank is open on the requested row;
  - 2 when the bank is open on a different row;
  - 1 when the bank is closed.
  
  With no request pending, `next_valid` is 0 and `next_cmd` is 0.
- R11: `req_valid` loads a request only when none is pending. A request offered while one is pending is dropped, and this includes the cycle in which a column command completes the old request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_code | input | 4 | Command issued to the bank this cycle (0 = none) |
| req_valid | input | 1 | Offer a new request |
| req_write | input | 1 | Direction of the offered request (1 = write) |
| req_row | input | ROW_W | Row of the offered request |
| block_set | input | 1 | Fence the bank until the next refresh |
| bank_open | output | 1 | A row is open in the bank |
| open_row | output | ROW_W | Row currently open |
| req_pending | output | 1 | A request waits for the bank |
| sleeping | output | 1 | Bank is in power-down or self-refresh |
| blocked | output | 1 | Bank is fenced off |
| next_valid | output | 1 | `next_cmd` holds a proposal |
| next_cmd | output | 4 | Proposed next command code |

## Verification
Every cycle, the assertions check the single-step effect of each command on its flag or bank state. They also check that a fenced or sleeping bank proposes nothing and that a proposed column access always targets the open row. Some behaviours appear only in the bench's scenarios:
- whole sequences, such as a row miss that goes precharge, activate and then column access;
- a second request dropped while one is pending;
- self-refresh exit leaving the bank asleep until a refresh;
- a fence and a refresh arriving in the same cycle.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;

    typedef enum logic [3:0] {
        CMD_NOP      = 4'd0,
        CMD_ACT      = 4'd1,
        CMD_PRE      = 4'd2,
        CMD_PREALL   = 4'd3,
        CMD_RD       = 4'd4,
        CMD_WR       = 4'd5,
        CMD_RDA      = 4'd6,
        CMD_WRA      = 4'd7,
        CMD_PDE_ACT  = 4'd8,
        CMD_PDE_PRE  = 4'd9,
        CMD_SR_ENTER = 4'd10,
        CMD_REF_ALL  = 4'd11,
        CMD_REF_BANK = 4'd12,
        CMD_PDX_ACT  = 4'd13,
        CMD_PDX_PRE  = 4'd14,
        CMD_SR_EXIT  = 4'd15
    } bank_cmd_e;

    localparam int CMD_W = 4;

    // Effect of one command on the tracked bank.
    typedef struct packed {
        logic opens;      // row becomes open
        logic closes;     // row becomes closed
        logic completes;  // pending request served
        logic sleeps;     // enter a low-power state
        logic wakes;      // leave a low-power state
        logic unblocks;   // fence lifted
    } cmd_effect_t;

    function automatic cmd_effect_t decode_cmd(bank_cmd_e c);
        cmd_effect_t e;
        e = '0;
        case (c)
            CMD_ACT:                   e.opens = 1'b1;
            CMD_PRE, CMD_PREALL:       e.closes = 1'b1;
            CMD_RD, CMD_WR:            e.completes = 1'b1;
            CMD_RDA, CMD_WRA: begin
                e.completes = 1'b1;
                e.closes    = 1'b1;
            end
            CMD_PDE_ACT, CMD_PDE_PRE,
            CMD_SR_ENTER:              e.sleeps = 1'b1;
            CMD_REF_ALL, CMD_REF_BANK: begin
                e.wakes    = 1'b1;
                e.unblocks = 1'b1;
            end
            CMD_PDX_ACT, CMD_PDX_PRE:  e.wakes = 1'b1;
            default:                   e = '0;
        endcase
        return e;
    endfunction

    function automatic bank_cmd_e column_cmd(logic is_write);
        return is_write ? CMD_WR : CMD_RD;
    endfunction

endpackage

// File: rtl/bank_req_slot.sv
module bank_req_slot #(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [ROW_W-1:0] req_row,
    input  logic             complete,
    output logic             pending,
    output logic             pend_write,
    output logic [ROW_W-1:0] pend_row
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending    <= 1'b0;
            pend_write <= 1'b0;
            pend_row   <= '0;
        end else if (complete) begin
            pending <= 1'b0;
        end else if (req_valid && !pending) begin
            pending    <= 1'b1;
            pend_write <= req_write;
            pend_row   <= req_row;
        end
    end

    a_r4_complete_clears: assert property (@(posedge clk) disable iff (rst)
        complete |=> !pending);

    a_r11_hold_while_pending: assert property (@(posedge clk) disable iff (rst)
        (pending && !complete) |=> (pending && $stable(pend_row) && $stable(pend_write)));

endmodule

// File: rtl/bank_row_state.sv
module bank_row_state #(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             opens,
    input  logic             closes,
    input  logic [ROW_W-1:0] pend_row,
    output logic             bank_open,
    output logic [ROW_W-1:0] open_row
);

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_open <= 1'b0;
            open_row  <= '0;
        end else if (opens) begin
            bank_open <= 1'b1;
            open_row  <= pend_row;
        end else if (closes) begin
            bank_open <= 1'b0;
        end
    end

    a_r2_activate_opens: assert property (@(posedge clk) disable iff (rst)
        opens |=> (bank_open && open_row == $past(pend_row)));

    a_r3_close: assert property (@(posedge clk) disable iff (rst)
        (closes && !opens) |=> !bank_open);

    a_r4_row_kept: assert property (@(posedge clk) disable iff (rst)
        (!opens && !closes) |=> ($stable(bank_open) && $stable(open_row)));

endmodule

// File: rtl/bank_power_flags.sv
module bank_power_flags (
    input  logic clk,
    input  logic rst,
    input  logic sleeps,
    input  logic wakes,
    input  logic unblocks,
    input  logic block_set,
    output logic sleeping,
    output logic blocked
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sleeping <= 1'b0;
            blocked  <= 1'b0;
        end else begin
            if (sleeps)
                sleeping <= 1'b1;
            else if (wakes)
                sleeping <= 1'b0;
            if (block_set)
                blocked <= 1'b1;
            else if (unblocks)
                blocked <= 1'b0;
        end
    end

    a_r6_enter_sleep: assert property (@(posedge clk) disable iff (rst)
        sleeps |=> sleeping);

    a_r7_refresh_clears: assert property (@(posedge clk) disable iff (rst)
        (unblocks && !block_set) |=> (!blocked && !sleeping));

    a_r8_exit_only_sleep: assert property (@(posedge clk) disable iff (rst)
        (wakes && !unblocks && !block_set) |=> (!sleeping && blocked == $past(blocked)));

    a_r9_fence: assert property (@(posedge clk) disable iff (rst)
        block_set |=> blocked);

endmodule

// File: rtl/bank_next_cmd.sv
module bank_next_cmd
    import bank_trk_pkg::*;
#(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pending,
    input  logic             pend_write,
    input  logic [ROW_W-1:0] pend_row,
    input  logic             bank_open,
    input  logic [ROW_W-1:0] open_row,
    input  logic             sleeping,
    input  logic             blocked,
    output logic             next_valid,
    output logic [CMD_W-1:0] next_cmd
);

    logic      row_hit;
    logic      may_issue;
    bank_cmd_e choice;

    assign row_hit   = bank_open && (open_row == pend_row);
    assign may_issue = pending && !sleeping && !blocked;

    always_comb begin
        if (!bank_open)
            choice = CMD_ACT;
        else if (row_hit)
            choice = column_cmd(pend_write);
        else
            choice = CMD_PRE;
    end

    assign next_valid = may_issue;
    assign next_cmd   = may_issue ? choice : CMD_NOP;

    a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
        (blocked || sleeping) |-> (!next_valid && next_cmd == CMD_NOP));

    a_r10_column_on_hit: assert property (@(posedge clk) disable iff (rst)
        (next_cmd == CMD_RD || next_cmd == CMD_WR) |-> (bank_open && open_row == pend_row));

    a_r10_act_when_closed: assert property (@(posedge clk) disable iff (rst)
        (next_valid && !bank_open) |-> next_cmd == CMD_ACT);

endmodule

// File: rtl/bank_state_tracker.sv
module bank_state_tracker
    import bank_trk_pkg::*;
#(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       cmd_code,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [ROW_W-1:0] req_row,
    input  logic             block_set,
    output logic             bank_open,
    output logic [ROW_W-1:0] open_row,
    output logic             req_pending,
    output logic             sleeping,
    output logic             blocked,
    output logic             next_valid,
    output logic [3:0]       next_cmd
);

    cmd_effect_t      eff;
    logic             pend_write;
    logic [ROW_W-1:0] pend_row;

    assign eff = decode_cmd(bank_cmd_e'(cmd_code));

    bank_req_slot #(.ROW_W(ROW_W)) u_slot (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_row    (req_row),
        .complete   (eff.completes),
        .pending    (req_pending),
        .pend_write (pend_write),
        .pend_row   (pend_row)
    );

    bank_row_state #(.ROW_W(ROW_W)) u_row (
        .clk       (clk),
        .rst       (rst),
        .opens     (eff.opens),
        .closes    (eff.closes),
        .pend_row  (pend_row),
        .bank_open (bank_open),
        .open_row  (open_row)
    );

    bank_power_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .sleeps    (eff.sleeps),
        .wakes     (eff.wakes),
        .unblocks  (eff.unblocks),
        .block_set (block_set),
        .sleeping  (sleeping),
        .blocked   (blocked)
    );

    bank_next_cmd #(.ROW_W(ROW_W)) u_next (
        .clk        (clk),
        .rst        (rst),
        .pending    (req_pending),
        .pend_write (pend_write),
        .pend_row   (pend_row),
        .bank_open  (bank_open),
        .open_row   (open_row),
        .sleeping   (sleeping),
        .blocked    (blocked),
        .next_valid (next_valid),
        .next_cmd   (next_cmd)
    );

    a_r5_autopre_closes: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == 4'd6 || cmd_code == 4'd7) |=> (!bank_open && !req_pending));

    a_r8_nop_stable: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == 4'd15 && !block_set && !req_valid) |=>
            ($stable(sleeping) && $stable(blocked) && $stable(bank_open) && $stable(req_pending)));

endmodule

// File: tb/bank_state_tracker_test.sv
module bank_state_tracker_test;

    localparam int RW = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    cmd_code = 4'd0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [RW-1:0] req_row = '0;
    logic          block_set = 1'b0;
    logic          bank_open, req_pending, sleeping, blocked, next_valid;
    logic [RW-1:0] open_row;
    logic [3:0]    next_cmd;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    bank_state_tracker #(.ROW_W(RW)) uut (
        .clk(clk), .rst(rst), .cmd_code(cmd_code), .req_valid(req_valid),
        .req_write(req_write), .req_row(req_row), .block_set(block_set),
        .bank_open(bank_open), .open_row(open_row), .req_pending(req_pending),
        .sleeping(sleeping), .blocked(blocked), .next_valid(next_valid),
        .next_cmd(next_cmd)
    );

    typedef struct packed {
        logic [3:0]    cmd;
        logic          rv;
        logic          rw;
        logic [RW-1:0] row;
        logic          bs;
        logic          eo;
        logic [RW-1:0] er;
        logic          ep;
        logic          es;
        logic          eb;
        logic          nv;
        logic [3:0]    nc;
        logic [23:0]   tag;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{4'd0,  1'b1, 1'b0, 14'd5, 1'b0, 1'b0, 14'd0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd1, "R10"},
        '{4'd1,  1'b0, 1'b0, 14'd0, 1'b0, 1'b1, 14'd5, 1'b1, 1'b0, 1'b0, 1'b1, 4'd4, "R2 "},
        '{4'd4,  1'b0, 1'b0, 14'd0, 1'b0, 1'b1, 14'd5, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, "R4 "},
        '{4'd0,  1'b1, 1'b1, 14'd9, 1'b0, 1'b1, 14'd5, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2, "R10"},
        '{4'd2,  1'b0, 1'b0, 14'd0, 1'b0, 1'b0, 14'd5, 1'b1, 1'b0, 1'b0, 1'b1, 4'd1, "R3 "},
        '{4'd1,  1'b0, 1'b0, 14'd0, 1'b0, 1'b1, 14'd9, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5, "R2 "},
        '{4'd0,  1'b1, 1'b0, 14'd3, 1'b0, 1'b1, 14'd9, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5, "R11"},
        '{4'd7,  1'b0, 1'b0, 14'd0, 1'b0, 1'b0, 14'd9, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, "R5 "},
        '{4'd0,  1'b1, 1'b0, 14'd9, 1'b0, 1'b0, 14'd9, 1'b1, 1'b0, 1'b0, 1'b1, 4'd1, "R10"},
        '{4'd1,  1'b0, 1'b0, 14'd0, 1'b0, 1'b1, 14'd9, 1'b1, 1'b0, 1'b0, 1'b1, 4'd4, "R2 "},
        '{4'd3,  1'b0, 1'b0, 14'd0, 1'b0, 1'b0, 14'd9, 1'b1, 1'b0, 1'b0, 1'b1, 4'd1, "R3 "},
        '{4'd1,  1'b0, 1'b0, 14'd0, 1'b0, 1'b1, 14'd9, 1'b1, 1'b0, 1'b0, 1'b1, 4'd4, "R10"},
        '{4'd6,  1'b0, 1'b0, 14'd0, 1'b0, 1'b0, 14'd9, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, "R5 "},
        '{4'd0,  1'b1, 1'b1, 14'd7, 1'b0, 1'b0, 14'd9, 1'b1, 1'b0, 1'b0, 1'b1, 4'd1, "R10"},
        '{4'd9,  1'b0, 1'b0, 14'd0, 1'b0, 1'b0, 14'd9, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, "R6 "},
        '{4'd15, 1'b0, 1'b0, 14'd0, 1'b0, 1'b0, 14'd9, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, "R8 "},
        '{4'd14, 1'b0, 1'b0, 14'd0, 1'b0, 1'b0, 14'd9, 1'b1, 1'b0, 1'b0, 1'b1, 4'd1, "R8 "},
        '{4'd0,  1'b0, 1'b0, 14'd0, 1'b1, 1'b0, 14'd9, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0, "R9 "},
        '{4'd13, 1'b0, 1'b0, 14'd0, 1'b0, 1'b0, 14'd9, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0, "R8 "},
        '{4'd12, 1'b0, 1'b0, 14'd0, 1'b0, 1'b0, 14'd9, 1'b1, 1'b0, 1'b0, 1'b1, 4'd1, "R7 "},
        '{4'd10, 1'b0, 1'b0, 14'd0, 1'b0, 1'b0, 14'd9, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, "R6 "},
        '{4'd11, 1'b0, 1'b0, 14'd0, 1'b0, 1'b0, 14'd9, 1'b1, 1'b0, 1'b0, 1'b1, 4'd1, "R7 "},
        '{4'd8,  1'b0, 1'b0, 14'd0, 1'b1, 1'b0, 14'd9, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0, "R6 "},
        '{4'd11, 1'b0, 1'b0, 14'd0, 1'b1, 1'b0, 14'd9, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0, "R7 "},
        '{4'd12, 1'b0, 1'b0, 14'd0, 1'b0, 1'b0, 14'd9, 1'b1, 1'b0, 1'b0, 1'b1, 4'd1, "R7 "},
        '{4'd1,  1'b0, 1'b0, 14'd0, 1'b0, 1'b1, 14'd7, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5, "R2 "},
        '{4'd5,  1'b0, 1'b0, 14'd0, 1'b0, 1'b1, 14'd7, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, "R4 "},
        '{4'd0,  1'b1, 1'b0, 14'd7, 1'b0, 1'b1, 14'd7, 1'b1, 1'b0, 1'b0, 1'b1, 4'd4, "R10"},
        '{4'd0,  1'b0, 1'b0, 14'd0, 1'b0, 1'b1, 14'd7, 1'b1, 1'b0, 1'b0, 1'b1, 4'd4, "R8 "},
        '{4'd4,  1'b1, 1'b1, 14'd1, 1'b0, 1'b1, 14'd7, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, "R11"}
    };

    task automatic check_outputs(input logic [23:0] tag, input logic eo, input logic [RW-1:0] er,
                                 input logic ep, input logic es, input logic eb,
                                 input logic nv, input logic [3:0] nc);
        logic [24:0] got, exp;
        got = {bank_open, open_row, req_pending, sleeping, blocked, next_valid, next_cmd};
        exp = {eo, er, ep, es, eb, nv, nc};
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s open=%b row=%0d pend=%b sleep=%b blk=%b nv=%b nc=%0d expected open=%b row=%0d pend=%b sleep=%b blk=%b nv=%b nc=%0d",
                     tag, bank_open, open_row, req_pending, sleeping, blocked, next_valid, next_cmd,
                     eo, er, ep, es, eb, nv, nc);
        end
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_outputs("R1 ", 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cmd_code  = VEC[i].cmd;
            req_valid = VEC[i].rv;
            req_write = VEC[i].rw;
            req_row   = VEC[i].row;
            block_set = VEC[i].bs;
            @(posedge clk);
            #1;
            check_outputs(VEC[i].tag, VEC[i].eo, VEC[i].er, VEC[i].ep, VEC[i].es,
                          VEC[i].eb, VEC[i].nv, VEC[i].nc);
        end

        // R1: reset mid-run with a request pending, a row open and the bank fenced
        @(negedge clk);
        cmd_code = 4'd0; req_valid = 1'b1; req_write = 1'b0; req_row = 14'd2; block_set = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; block_set = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        #1;
        check_outputs("R1 ", 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);

        // R2 / R10: after reset, a request to row 0 misses because the bank is closed
        @(negedge clk);
        rst = 1'b0; req_valid = 1'b1; req_write = 1'b1; req_row = 14'd0;
        @(posedge clk);
        #1;
        check_outputs("R10", 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd1);
        @(negedge clk);
        req_valid = 1'b0; cmd_code = 4'd1;
        @(posedge clk);
        #1;
        check_outputs("R2 ", 1'b1, '0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5);

        // R9: sleep while open on a hit proposes nothing
        @(negedge clk);
        cmd_code = 4'd8;
        @(posedge clk);
        #1;
        check_outputs("R9 ", 1'b1, '0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0);

        @(negedge clk);
        cmd_code = 4'd0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule